// File: doc/BRIEF.md
# Banked GPIO Port Controller

This block gives software control of general-purpose pins arranged in four groups, all reached through one small register bus. Groups 0, 1 and 2 are ordinary bidirectional ports in which pin n sits at bit n. Group 3 combines three kinds of pin: six bidirectional pins, input-only pins and output-only pins. Their bit positions are spread across the group's registers rather than packed together.

Software never writes an output level or a direction word directly. Each group has a pair of strobe registers for the output level and a pair for the direction. A 1 written to one of them sets or clears only that pin, and a 0 leaves the pin alone. Reading either register of a pair returns the latch behind it. Pin levels are read from a state register after they pass through a two-flop synchroniser. The bus decodes the address as `addr[4:3]` = group and `addr[2:0]` = register: 0 state, 1 output set, 2 output clear, 3 direction set, 4 direction clear. Writes take effect on the clock edge where `bus_wen` is high, and read data is combinational from `bus_addr`.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output latch and direction latch clears. All pin outputs are then low, all output enables are low (input), and reading any set or clear register returns 0.
- R2: A write to output set (register 1) sets the output latch bits where the data is 1 and leaves the bits where it is 0 unchanged. For groups 0 to 2, pin n uses bit n.
- R3: A write to output clear (register 2) clears the output latch bits where the data is 1 and leaves the other bits unchanged.
- R4: Direction set (register 3) writes 1 into the chosen direction bits, and direction clear (register 4) writes 0. A direction bit of 1 drives the pin's output enable high, which makes the pin an output.
- R5: Reading register 1 or 2 returns the group's output latch. Reading register 3 or 4 returns its direction latch.
- R6: A pin input change reaches the state register (register 0) on the second rising edge after it is applied. The state register reports the pin level whatever the pin's direction.
- R7: Group 3 bidirectional pin n (n = 0 to 5) uses bit n+25 of the output and direction latches.
- R8: In the group 3 state register, bidirectional pin n appears at bit 10+n for n = 0 to 4, and pin 5 appears at bit 24.
- R9: Group 3 input-only line k appears at state bit k for k in 0..9, 15..23 and 25..27. Input-only lines 10..14 and 24 have no effect, and state bits 28..31 read 0.
- R10: Group 3 output-only pins 0 to 23 follow output latch bits 0 to 23 and are always driven. Direction writes to group 3 do not change them, and group 3 bits 24 and 31 ignore writes.
- R11: Latch bits at or above a group's pin count (8, 24, 13 for groups 0, 1, 2) ignore writes and read 0. Register offsets 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Group in [4:3], register in [2:0] |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for bus_addr |
| g0_in | input | P0_PINS | Group 0 pin levels |
| g0_out | output | P0_PINS | Group 0 output levels |
| g0_oe | output | P0_PINS | Group 0 output enables |
| g1_in | input | P1_PINS | Group 1 pin levels |
| g1_out | output | P1_PINS | Group 1 output levels |
| g1_oe | output | P1_PINS | Group 1 output enables |
| g2_in | input | P2_PINS | Group 2 pin levels |
| g2_out | output | P2_PINS | Group 2 output levels |
| g2_oe | output | P2_PINS | Group 2 output enables |
| g3io_in | input | 6 | Group 3 bidirectional pin levels |
| g3io_out | output | 6 | Group 3 bidirectional output levels |
| g3io_oe | output | 6 | Group 3 bidirectional output enables |
| g3i_in | input | 28 | Group 3 input-only lines |
| g3o_out | output | 24 | Group 3 output-only pins |

## Verification
The hardest situation to reach is an input-only line and a bidirectional pin of group 3 that both compete for the same state bits (10..14 and 24). The stimulus drives all 28 input-only lines high while the bidirectional inputs are low, and then does the reverse. That exposes which source owns each shared bit. The bidirectional pins' output and direction bits lie next to the output-only field, so all-ones writes followed by sparse clears show that bits 24 and 31 and the low direction bits never latch.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NGRP      = 4;
    localparam int DW        = 32;
    localparam int AW        = 5;

    // group 3 layout
    localparam int G3_IO_PINS    = 6;
    localparam int G3_IO_LSB     = 25;   // bidir pins in output/direction latches
    localparam int G3_IO_IN_LSB  = 10;   // bidir pins 0..4 in state
    localparam int G3_IO_IN_LAST = 24;   // bidir pin 5 in state
    localparam int G3_GPI_PINS   = 28;
    localparam int G3_GPO_PINS   = 24;

    typedef enum logic [2:0] {
        REG_STATE   = 3'd0,
        REG_OUT_SET = 3'd1,
        REG_OUT_CLR = 3'd2,
        REG_DIR_SET = 3'd3,
        REG_DIR_CLR = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] grp;
        reg_sel_e   sel;
    } bus_dec_t;

    function automatic logic [DW-1:0] low_ones(int n);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < DW; i++)
            if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [DW-1:0] io_field();
        return low_ones(G3_IO_PINS) << G3_IO_LSB;
    endfunction

    function automatic logic [DW-1:0] out_mask(int g, int p0, int p1, int p2);
        case (g)
            0:       return low_ones(p0);
            1:       return low_ones(p1);
            2:       return low_ones(p2);
            default: return low_ones(G3_GPO_PINS) | io_field();
        endcase
    endfunction

    function automatic logic [DW-1:0] dir_mask(int g, int p0, int p1, int p2);
        case (g)
            0:       return low_ones(p0);
            1:       return low_ones(p1);
            2:       return low_ones(p2);
            default: return io_field();
        endcase
    endfunction

    // state word of group 3: bidir pins overlay input-only positions
    function automatic logic [DW-1:0] g3_state(logic [G3_GPI_PINS-1:0] gpi,
                                               logic [G3_IO_PINS-1:0]  io);
        logic [DW-1:0] s;
        s = '0;
        s[G3_GPI_PINS-1:0] = gpi;
        s[G3_IO_IN_LSB +: G3_IO_PINS-1] = io[G3_IO_PINS-2:0];
        s[G3_IO_IN_LAST] = io[G3_IO_PINS-1];
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
    parameter int           W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    logic [W-1:0] sel_bits;
    assign sel_bits = bits & MASK;

    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (set_stb) q <= q | sel_bits;
        else if (clr_stb) q <= q & ~sel_bits;
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int P0_PINS     = 8,
    parameter int P1_PINS     = 24,
    parameter int P2_PINS     = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wen,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    input  logic [P0_PINS-1:0]     g0_in,
    output logic [P0_PINS-1:0]     g0_out,
    output logic [P0_PINS-1:0]     g0_oe,
    input  logic [P1_PINS-1:0]     g1_in,
    output logic [P1_PINS-1:0]     g1_out,
    output logic [P1_PINS-1:0]     g1_oe,
    input  logic [P2_PINS-1:0]     g2_in,
    output logic [P2_PINS-1:0]     g2_out,
    output logic [P2_PINS-1:0]     g2_oe,
    input  logic [G3_IO_PINS-1:0]  g3io_in,
    output logic [G3_IO_PINS-1:0]  g3io_out,
    output logic [G3_IO_PINS-1:0]  g3io_oe,
    input  logic [G3_GPI_PINS-1:0] g3i_in,
    output logic [G3_GPO_PINS-1:0] g3o_out
);
    localparam int G3_SYNC_W = G3_GPI_PINS + G3_IO_PINS;

    bus_dec_t dec;
    assign dec.grp = bus_addr[4:3];
    assign dec.sel = reg_sel_e'(bus_addr[2:0]);

    logic [NGRP-1:0][DW-1:0] out_q, dir_q, state;

    // ---------------- set/clear latches ----------------
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic hit;
        assign hit = bus_wen && (dec.grp == 2'(g));

        gpio_setclr_reg #(
            .W   (DW),
            .MASK(out_mask(g, P0_PINS, P1_PINS, P2_PINS))
        ) u_out (
            .clk    (clk),
            .rst    (rst),
            .set_stb(hit && dec.sel == REG_OUT_SET),
            .clr_stb(hit && dec.sel == REG_OUT_CLR),
            .bits   (bus_wdata),
            .q      (out_q[g])
        );

        gpio_setclr_reg #(
            .W   (DW),
            .MASK(dir_mask(g, P0_PINS, P1_PINS, P2_PINS))
        ) u_dir (
            .clk    (clk),
            .rst    (rst),
            .set_stb(hit && dec.sel == REG_DIR_SET),
            .clr_stb(hit && dec.sel == REG_DIR_CLR),
            .bits   (bus_wdata),
            .q      (dir_q[g])
        );
    end

    // ---------------- input synchronisers ----------------
    logic [P0_PINS-1:0]   s0;
    logic [P1_PINS-1:0]   s1;
    logic [P2_PINS-1:0]   s2;
    logic [G3_SYNC_W-1:0] s3;

    gpio_sync #(.W(P0_PINS), .STAGES(SYNC_STAGES)) u_sync0 (
        .clk(clk), .rst(rst), .d(g0_in), .q(s0));
    gpio_sync #(.W(P1_PINS), .STAGES(SYNC_STAGES)) u_sync1 (
        .clk(clk), .rst(rst), .d(g1_in), .q(s1));
    gpio_sync #(.W(P2_PINS), .STAGES(SYNC_STAGES)) u_sync2 (
        .clk(clk), .rst(rst), .d(g2_in), .q(s2));
    gpio_sync #(.W(G3_SYNC_W), .STAGES(SYNC_STAGES)) u_sync3 (
        .clk(clk), .rst(rst), .d({g3io_in, g3i_in}), .q(s3));

    always_comb begin
        state    = '0;
        state[0][P0_PINS-1:0] = s0;
        state[1][P1_PINS-1:0] = s1;
        state[2][P2_PINS-1:0] = s2;
        state[3] = g3_state(s3[G3_GPI_PINS-1:0], s3[G3_SYNC_W-1:G3_GPI_PINS]);
    end

    // ---------------- read mux ----------------
    always_comb begin
        case (dec.sel)
            REG_STATE:                bus_rdata = state[dec.grp];
            REG_OUT_SET, REG_OUT_CLR: bus_rdata = out_q[dec.grp];
            REG_DIR_SET, REG_DIR_CLR: bus_rdata = dir_q[dec.grp];
            default:                  bus_rdata = '0;
        endcase
    end

    // ---------------- pin mapping ----------------
    assign g0_out   = out_q[0][P0_PINS-1:0];
    assign g0_oe    = dir_q[0][P0_PINS-1:0];
    assign g1_out   = out_q[1][P1_PINS-1:0];
    assign g1_oe    = dir_q[1][P1_PINS-1:0];
    assign g2_out   = out_q[2][P2_PINS-1:0];
    assign g2_oe    = dir_q[2][P2_PINS-1:0];
    assign g3io_out = out_q[3][G3_IO_LSB +: G3_IO_PINS];
    assign g3io_oe  = dir_q[3][G3_IO_LSB +: G3_IO_PINS];
    assign g3o_out  = out_q[3][G3_GPO_PINS-1:0];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int P0_PINS = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wen,
    input logic [4:0]         bus_addr,
    input logic [P0_PINS-1:0] wdata_lo,
    input logic [31:0]        bus_rdata,
    input logic [P0_PINS-1:0] g0_in,
    input logic [P0_PINS-1:0] g0_out,
    input logic [P0_PINS-1:0] g0_oe,
    input logic [5:0]         g3io_oe,
    input logic [23:0]        g3o_out
);
    logic [1:0] live_cnt;
    always_ff @(posedge clk) begin
        if (rst)                live_cnt <= '0;
        else if (live_cnt != 2) live_cnt <= live_cnt + 2'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (g0_out == '0 && g0_oe == '0 && g3io_oe == '0 && g3o_out == '0)); // R1

    AST_G0_SET_OR: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == 5'h01) |=> g0_out == ($past(g0_out) | $past(wdata_lo))); // R2

    AST_G0_CLR_AND: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == 5'h02) |=> g0_out == ($past(g0_out) & ~$past(wdata_lo))); // R3

    AST_G0_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_wen && (bus_addr == 5'h03 || bus_addr == 5'h04)) |=> $stable(g0_oe)); // R4

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        (live_cnt == 2 && bus_addr == 5'h00) |-> bus_rdata[P0_PINS-1:0] == $past(g0_in, 2)); // R6

    AST_GPO_IGNORES_DIR: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && (bus_addr == 5'h1B || bus_addr == 5'h1C)) |=> $stable(g3o_out)); // R10

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[2:0] > 3'd4) |-> bus_rdata == '0); // R11
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.P0_PINS(P0_PINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wen  (bus_wen),
    .bus_addr (bus_addr),
    .wdata_lo (bus_wdata[P0_PINS-1:0]),
    .bus_rdata(bus_rdata),
    .g0_in    (g0_in),
    .g0_out   (g0_out),
    .g0_oe    (g0_oe),
    .g3io_oe  (g3io_oe),
    .g3o_out  (g3o_out)
);

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wen = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  g0_in = '0, g0_out, g0_oe;
    logic [23:0] g1_in = '0, g1_out, g1_oe;
    logic [12:0] g2_in = '0, g2_out, g2_oe;
    logic [5:0]  g3io_in = '0, g3io_out, g3io_oe;
    logic [27:0] g3i_in = '0;
    logic [23:0] g3o_out;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    gpio_bank_ctrl i_gpio_bank_ctrl (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .g0_in(g0_in), .g0_out(g0_out), .g0_oe(g0_oe),
        .g1_in(g1_in), .g1_out(g1_out), .g1_oe(g1_oe),
        .g2_in(g2_in), .g2_out(g2_out), .g2_oe(g2_oe),
        .g3io_in(g3io_in), .g3io_out(g3io_out), .g3io_oe(g3io_oe),
        .g3i_in(g3i_in), .g3o_out(g3o_out)
    );

    typedef struct packed {
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic [4:0]  raddr;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{5'h01, 32'hFF0000A5, 5'h01, 32'h000000A5, 4'd2},  // R2 with R11 high bits
        '{5'h02, 32'h00000021, 5'h01, 32'h00000084, 4'd3},  // R3
        '{5'h09, 32'hFFFFFFFF, 5'h0A, 32'h00FFFFFF, 4'd5},  // R5 R11
        '{5'h0A, 32'h00F0000F, 5'h09, 32'h000FFFF0, 4'd3},  // R3
        '{5'h13, 32'h0000FFFF, 5'h14, 32'h00001FFF, 4'd4},  // R4 R11
        '{5'h14, 32'h00001001, 5'h13, 32'h00000FFE, 4'd4},  // R4
        '{5'h19, 32'hFFFFFFFF, 5'h19, 32'h7EFFFFFF, 4'd10}, // R10 R7
        '{5'h1A, 32'h42000F00, 5'h1A, 32'h3CFFF0FF, 4'd7},  // R7
        '{5'h1B, 32'hFFFFFFFF, 5'h1C, 32'h7E000000, 4'd7},  // R7 R10
        '{5'h1C, 32'h0A000000, 5'h1B, 32'h74000000, 4'd7},  // R7
        '{5'h05, 32'hFFFFFFFF, 5'h05, 32'h00000000, 4'd11}  // R11
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 g0_out", {24'h0, g0_out}, 32'h0);
        chk("R1 g0_oe", {24'h0, g0_oe}, 32'h0);
        chk("R1 g3o_out", {8'h0, g3o_out}, 32'h0);
        rd_chk("R1 g3 out latch", 5'h19, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].waddr, VECS[i].wdata);
            rd_chk($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].raddr, VECS[i].exp);
        end

        // pins after the table
        chk("R2 g0_out pins", {24'h0, g0_out}, 32'h84);
        chk("R3 g1_out pins", {8'h0, g1_out}, 32'h000FFFF0);
        chk("R4 g2_oe pins", {19'h0, g2_oe}, 32'h0FFE);
        chk("R7 g3io_out pins", {26'h0, g3io_out}, 32'h1E);
        chk("R7 g3io_oe pins", {26'h0, g3io_oe}, 32'h3A);
        chk("R10 g3o_out pins", {8'h0, g3o_out}, 32'h00FFF0FF);

        // R6: two-edge synchroniser delay on group 0
        @(negedge clk);
        bus_addr = 5'h00;
        g0_in = 8'h5A;
        @(negedge clk);
        rd_chk("R6 after one edge", 5'h00, 32'h0);
        @(negedge clk);
        rd_chk("R6 after two edges", 5'h00, 32'h5A);

        // R6: state follows pins of an output-configured group
        g2_in = 13'h1555;
        repeat (2) @(negedge clk);
        rd_chk("R6 g2 state while output", 5'h10, 32'h00001555);

        // R9: input-only lines on group 3
        g3i_in = 28'hFFFFFFF; g3io_in = 6'h00;
        repeat (2) @(negedge clk);
        rd_chk("R9 gpi all high", 5'h18, 32'h0EFF83FF);

        // R8: bidir inputs on group 3
        g3i_in = '0; g3io_in = 6'h3F;
        repeat (2) @(negedge clk);
        rd_chk("R8 bidir all high", 5'h18, 32'h01007C00);
        g3io_in = 6'b100001;
        repeat (2) @(negedge clk);
        rd_chk("R8 bidir pins 0 and 5", 5'h18, 32'h01000400);

        // R1: reset again clears latches
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 g3io_oe after reset", {26'h0, g3io_oe}, 32'h0);
        chk("R1 g1_out after reset", {8'h0, g1_out}, 32'h0);
        rd_chk("R1 g2 dir latch after reset", 5'h13, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule